// File: doc/BRIEF.md
# Reset, Watchdog and Power-Mode Controller

This block decides when the rest of the chip is held in reset and which clocks run. A reset line arriving from the board counts as a real reset only after it has stayed high long enough: a fixed number of consecutive oscillator periods, 24 by default. An 8-bit watchdog counter runs from a prescaled tick whenever a dedicated enable pin is high. When the counter wraps, the block drives the bidirectional reset pin high for a fixed pulse and holds the core in reset for that time.

Software selects the low-power states through a small write port. Idle stops only the CPU clock and ends on any pending enabled interrupt. Power-down stops every clock and asks the oscillator to halt, and only a qualified external reset ends it. Power-down is refused while the watchdog enable pin is high. The watchdog reload value may be changed only after a two-write unlock sequence.

Top module: `sysrc_ctrl`

## Requirements
- R1: After the asynchronous reset is released, the block is in run mode: `cpu_clk_en`=1, `periph_clk_en`=1, `osc_stop_req`=0, `core_rst`=0, `rst_pin_oe`=0.
- R2: `core_rst` rises only after `rst_pin_in` has been sampled high on MIN_RST_CYC (24) consecutive clock edges. Any low sample restarts the count. `core_rst` falls on the first edge that samples the pin low.
- R3: While `wdt_en_pin` is high and the mode is not power-down, the watchdog counter steps once every PRESC_DIV (4) cycles. Starting from reload value R, it overflows (256-R)*PRESC_DIV cycles after the enable pin rises.
- R4: A watchdog overflow drives `rst_pin_oe` high, and `core_rst` with it, for exactly PULSE_CYC (24) cycles.
- R5: Writes use `wr_sel`: 0 = mode control, 1 = watchdog reload, 2 = key. A reload write takes effect only if it follows a key write of 8'h5A and then a key write of 8'hC3, with no other write in between. Any other reload write is ignored and leaves the old reload value.
- R6: A mode-control write with bit 0 set (and bit 1 clear, or bit 1 refused) enters idle on the next cycle: `cpu_clk_en`=0 and `periph_clk_en`=1. Idle returns to run on the cycle after `irq_pending` is sampled high.
- R7: A mode-control write with bit 1 set enters power-down: both clock enables are 0 and `osc_stop_req`=1. In power-down, `irq_pending` has no effect, and `osc_stop_req` is 0 while `rst_pin_in` is high. A qualified external reset returns the block to run mode.
- R8: With both mode bits set, power-down wins over idle.
- R9: While `wdt_en_pin` is high, mode bit 1 is ignored. Bit 0 still selects idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_in | input | 1 | Level sensed on the reset pin |
| rst_pin_oe | output | 1 | Drives the reset pin high during a watchdog pulse |
| wdt_en_pin | input | 1 | Watchdog enable, also forbids power-down |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| wr_valid | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 reload, 2 key |
| wr_data | input | 8 | Write data |
| core_rst | output | 1 | Reset to the core and peripherals, active high |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_stop_req | output | 1 | Request to halt the oscillator |

## Verification
The hardest case to reach is a watchdog overflow from a known reload value. The counter is invisible, and with the reset value of zero an overflow takes a thousand cycles. The stimulus first unlocks the key sequence and loads a reload value near the top, with the enable pin low so the counter stays parked. It then raises the pin and counts the exact cycles to the pin pulse. A broken unlock sequence is then shown to be ignored: the overflow delay stays the same.

// File: rtl/sysrc_pkg.sv
package sysrc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pmode_e;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_RELOAD = 2'd1;
  localparam logic [1:0] SEL_KEY    = 2'd2;

  localparam logic [7:0] KEY_FIRST  = 8'h5A;
  localparam logic [7:0] KEY_SECOND = 8'hC3;
endpackage

// File: rtl/sysrc_pin_qual.sv
module sysrc_pin_qual #(
  parameter int MIN_CYC   = 24,
  parameter int PULSE_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic wdt_ovf,
  output logic ext_rst,
  output logic pin_oe
);
  localparam int QW = $clog2(MIN_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(MIN_CYC);
  localparam logic [PW-1:0] PMAX = PW'(PULSE_CYC);

  logic [QW-1:0] qual_q, qual_d;
  logic [PW-1:0] pulse_q, pulse_d;

  always_comb begin
    qual_d = qual_q;
    if (pin_oe || !pin_in) qual_d = '0;
    else if (qual_q != QMAX) qual_d = qual_q + 1'b1;

    pulse_d = pulse_q;
    if (wdt_ovf) pulse_d = PMAX;
    else if (pulse_q != '0) pulse_d = pulse_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q  <= '0;
      pulse_q <= '0;
    end else begin
      qual_q  <= qual_d;
      pulse_q <= pulse_d;
    end
  end

  assign ext_rst = (qual_q == QMAX);
  assign pin_oe  = (pulse_q != '0);
endmodule

// File: rtl/sysrc_wdt.sv
module sysrc_wdt
  import sysrc_pkg::*;
#(
  parameter int PRESC_DIV = 4,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             run,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             ovf
);
  localparam int PSW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PSW-1:0]   PS_LAST = PSW'(PRESC_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  typedef enum logic [1:0] {UL_NONE, UL_HALF, UL_OPEN} unlock_e;

  logic [CNT_W-1:0] cnt_q, cnt_d, reload_q, reload_d;
  logic [PSW-1:0]   ps_q, ps_d;
  unlock_e          ul_q, ul_d;
  logic             tick;

  assign tick = run && (ps_q == PS_LAST);
  assign ovf  = tick && (cnt_q == CNT_TOP) && !soft_clr;

  always_comb begin
    cnt_d    = cnt_q;
    ps_d     = ps_q;
    reload_d = reload_q;
    ul_d     = ul_q;
    if (soft_clr) begin
      cnt_d = reload_q;
      ps_d  = '0;
      ul_d  = UL_NONE;
    end else begin
      if (run) begin
        ps_d = tick ? '0 : ps_q + 1'b1;
        if (tick) cnt_d = (cnt_q == CNT_TOP) ? reload_q : cnt_q + 1'b1;
      end else begin
        ps_d  = '0;
        cnt_d = reload_q;
      end
      if (wr_en) begin
        ul_d = UL_NONE;
        if (wr_sel == SEL_KEY) begin
          if (wr_data == KEY_FIRST) ul_d = UL_HALF;
          else if (wr_data == KEY_SECOND && ul_q == UL_HALF) ul_d = UL_OPEN;
        end else if (wr_sel == SEL_RELOAD && ul_q == UL_OPEN) begin
          reload_d = wr_data;
          cnt_d    = wr_data;
          ps_d     = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ps_q     <= '0;
      reload_q <= '0;
      ul_q     <= UL_NONE;
    end else begin
      cnt_q    <= cnt_d;
      ps_q     <= ps_d;
      reload_q <= reload_d;
      ul_q     <= ul_d;
    end
  end
endmodule

// File: rtl/sysrc_pmode.sv
module sysrc_pmode
  import sysrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_rst,
  input  logic       wr_valid,
  input  logic [1:0] wr_sel,
  input  logic [1:0] mode_bits,
  input  logic       wdt_en,
  input  logic       irq,
  input  logic       pin_in,
  output pmode_e     mode,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_stop_req
);
  pmode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (core_rst) begin
      mode_d = PM_RUN;
    end else begin
      case (mode_q)
        PM_RUN:
          if (wr_valid && wr_sel == SEL_MODE) begin
            if (mode_bits[1] && !wdt_en) mode_d = PM_PDOWN;
            else if (mode_bits[0])       mode_d = PM_IDLE;
          end
        PM_IDLE:
          if (irq) mode_d = PM_RUN;
        default: mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end

  assign mode          = mode_q;
  assign cpu_clk_en    = (mode_q == PM_RUN);
  assign periph_clk_en = (mode_q != PM_PDOWN);
  assign osc_stop_req  = (mode_q == PM_PDOWN) && !pin_in;
endmodule

// File: rtl/sysrc_ctrl.sv
module sysrc_ctrl
  import sysrc_pkg::*;
#(
  parameter int MIN_RST_CYC = 24,
  parameter int PULSE_CYC   = 24,
  parameter int PRESC_DIV   = 4,
  parameter int WDT_W       = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_pin_in,
  output logic             rst_pin_oe,
  input  logic             wdt_en_pin,
  input  logic             irq_pending,
  input  logic             wr_valid,
  input  logic [1:0]       wr_sel,
  input  logic [WDT_W-1:0] wr_data,
  output logic             core_rst,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_stop_req
);
  logic [1:0] rst_sync_q;
  logic       rst_n_q;
  logic       ext_rst, wdt_ovf, wdt_run, wdt_wr_en;
  pmode_e     mode;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  assign core_rst  = ext_rst || rst_pin_oe;
  assign wdt_run   = wdt_en_pin && (mode != PM_PDOWN);
  assign wdt_wr_en = wr_valid && (mode == PM_RUN);

  sysrc_pin_qual #(.MIN_CYC(MIN_RST_CYC), .PULSE_CYC(PULSE_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n_q), .pin_in(rst_pin_in), .wdt_ovf(wdt_ovf),
    .ext_rst(ext_rst), .pin_oe(rst_pin_oe)
  );

  sysrc_wdt #(.PRESC_DIV(PRESC_DIV), .CNT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n_q), .soft_clr(core_rst), .run(wdt_run),
    .wr_en(wdt_wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ovf(wdt_ovf)
  );

  sysrc_pmode u_pmode (
    .clk(clk), .rst_n(rst_n_q), .core_rst(core_rst), .wr_valid(wr_valid),
    .wr_sel(wr_sel), .mode_bits(wr_data[1:0]), .wdt_en(wdt_en_pin),
    .irq(irq_pending), .pin_in(rst_pin_in), .mode(mode),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_stop_req(osc_stop_req)
  );
endmodule

// File: rtl/sysrc_ctrl_chk.sv
module sysrc_ctrl_chk
  import sysrc_pkg::*;
#(
  parameter int MIN_RST_CYC = 24,
  parameter int PULSE_CYC   = 24
) (
  input logic   clk,
  input logic   rst_n_q,
  input logic   rst_pin_in,
  input logic   rst_pin_oe,
  input logic   wdt_en_pin,
  input logic   irq_pending,
  input logic   core_rst,
  input logic   cpu_clk_en,
  input logic   periph_clk_en,
  input pmode_e mode
);
  logic [15:0] hi_run_q, oe_len_q;

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      hi_run_q <= '0;
      oe_len_q <= '0;
    end else begin
      if (rst_pin_in && !rst_pin_oe) hi_run_q <= (hi_run_q == 16'hFFFF) ? hi_run_q : hi_run_q + 1'b1;
      else hi_run_q <= '0;
      oe_len_q <= rst_pin_oe ? oe_len_q + 1'b1 : '0;
    end
  end

  // R2
  ext_qual_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (core_rst && !rst_pin_oe) |-> (hi_run_q >= 16'(MIN_RST_CYC)));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    $fell(rst_pin_oe) |-> (oe_len_q == 16'(PULSE_CYC)));

  // R9
  no_pdown_when_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (mode == PM_PDOWN && $past(mode) != PM_PDOWN) |-> !$past(wdt_en_pin));

  // R7
  pdown_exit_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    ($past(mode) == PM_PDOWN && mode != PM_PDOWN) |-> $past(core_rst));

  // R6
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    ($past(mode) == PM_IDLE && mode == PM_RUN) |-> $past(irq_pending || core_rst));

  // R6
  clk_gate_order_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    cpu_clk_en |-> periph_clk_en);
endmodule

bind sysrc_ctrl sysrc_ctrl_chk #(.MIN_RST_CYC(MIN_RST_CYC), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .rst_pin_in(rst_pin_in), .rst_pin_oe(rst_pin_oe),
  .wdt_en_pin(wdt_en_pin), .irq_pending(irq_pending), .core_rst(core_rst),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .mode(mode)
);

// File: tb/sysrc_ctrl_tb.sv
`timescale 1ns/1ps
module sysrc_ctrl_tb;
  logic       clk = 1'b0;
  logic       arst_n, rst_pin_in, wdt_en_pin, irq_pending, wr_valid;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       rst_pin_oe, core_rst, cpu_clk_en, periph_clk_en, osc_stop_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sysrc_ctrl u_dut (
    .clk(clk), .arst_n(arst_n), .rst_pin_in(rst_pin_in), .rst_pin_oe(rst_pin_oe),
    .wdt_en_pin(wdt_en_pin), .irq_pending(irq_pending), .wr_valid(wr_valid),
    .wr_sel(wr_sel), .wr_data(wr_data), .core_rst(core_rst),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_stop_req(osc_stop_req)
  );

  // {en_pin, mode bits[1:0], exp cpu_clk_en, exp periph_clk_en, exp osc_stop_req}
  localparam logic [5:0] VEC [0:5] = '{
    6'b0_00_110,  // R6: no bits, stays in run
    6'b0_01_010,  // R6: idle
    6'b0_10_001,  // R7: power-down
    6'b0_11_001,  // R8: power-down wins
    6'b1_10_110,  // R9: power-down refused
    6'b1_11_010   // R9: idle still honoured
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ovf_delay(output int n);
    n = 0;
    @(negedge clk);
    wdt_en_pin = 1'b1;
    while (!rst_pin_oe && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_len(output int k);
    k = 1;
    while (rst_pin_oe && k < 100) begin
      @(negedge clk);
      if (rst_pin_oe) k++;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    arst_n = 1'b0; rst_pin_in = 1'b0; wdt_en_pin = 1'b0; irq_pending = 1'b0;
    wr_valid = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 periph_clk_en", periph_clk_en, 1);
    chk("R1 osc_stop_req", osc_stop_req, 0);
    chk("R1 core_rst", core_rst, 0);
    chk("R1 rst_pin_oe", rst_pin_oe, 0);

    // mode table
    for (int i = 0; i < 6; i++) begin
      wdt_en_pin = VEC[i][5];
      wr(2'd0, {6'b0, VEC[i][4:3]});
      chk($sformatf("R6/R7/R8/R9 v%0d cpu", i), cpu_clk_en, VEC[i][2]);
      chk($sformatf("R6/R7/R8/R9 v%0d periph", i), periph_clk_en, VEC[i][1]);
      chk($sformatf("R6/R7/R8/R9 v%0d osc", i), osc_stop_req, VEC[i][0]);
      wdt_en_pin = 1'b0;
      irq_pending = 1'b1;
      @(negedge clk);
      irq_pending = 1'b0;
      if (VEC[i][0]) begin
        chk($sformatf("R7 v%0d irq ignored cpu", i), cpu_clk_en, 0);
        chk($sformatf("R7 v%0d irq ignored periph", i), periph_clk_en, 0);
        rst_pin_in = 1'b1;
        repeat (5) @(negedge clk);
        chk($sformatf("R7 v%0d osc released", i), osc_stop_req, 0);
        repeat (25) @(negedge clk);
        chk($sformatf("R2 v%0d core_rst", i), core_rst, 1);
        rst_pin_in = 1'b0;
        @(negedge clk);
      end else begin
        chk($sformatf("R6 v%0d back to run", i), cpu_clk_en, 1);
      end
      chk($sformatf("R7 v%0d run periph", i), periph_clk_en, 1);
      chk($sformatf("R2 v%0d core_rst low", i), core_rst, 0);
    end

    // R2 qualification boundaries
    @(negedge clk);
    rst_pin_in = 1'b1;
    repeat (10) @(negedge clk);
    rst_pin_in = 1'b0;
    @(negedge clk);
    rst_pin_in = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 broken run not accepted", core_rst, 0);
    rst_pin_in = 1'b0;
    @(negedge clk);
    rst_pin_in = 1'b1;
    repeat (23) @(negedge clk);
    chk("R2 23 cycles", core_rst, 0);
    @(negedge clk);
    chk("R2 24 cycles", core_rst, 1);
    rst_pin_in = 1'b0;
    @(negedge clk);
    chk("R2 release", core_rst, 0);

    // R5 unlock, R3 timing, R4 pulse
    wr(2'd2, 8'h5A);
    wr(2'd2, 8'hC3);
    wr(2'd1, 8'hFC);
    ovf_delay(n);
    chk("R3 overflow delay reload FC", n, 16);
    chk("R4 core_rst during pulse", core_rst, 1);
    pulse_len(n);
    wdt_en_pin = 1'b0;
    chk("R4 pulse length", n, 24);
    @(negedge clk);
    chk("R4 pin released", rst_pin_oe, 0);

    // R5 broken unlock: reload write ignored
    wr(2'd2, 8'h5A);
    wr(2'd2, 8'h11);
    wr(2'd1, 8'h00);
    ovf_delay(n);
    chk("R5 reload ignored", n, 16);
    wdt_en_pin = 1'b0;
    repeat (30) @(negedge clk);

    // R5 second-key without first
    wr(2'd2, 8'hC3);
    wr(2'd1, 8'h00);
    ovf_delay(n);
    chk("R5 lone second key", n, 16);
    wdt_en_pin = 1'b0;
    repeat (30) @(negedge clk);

    // R5 proper unlock to FE, R3
    wr(2'd2, 8'h5A);
    wr(2'd2, 8'hC3);
    wr(2'd1, 8'hFE);
    ovf_delay(n);
    chk("R3 overflow delay reload FE", n, 8);
    wdt_en_pin = 1'b0;
    repeat (30) @(negedge clk);
    chk("R1 final run state", cpu_clk_en, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule